// File: doc/BRIEF.md
# Event Word Manchester Serializer

This block moves fixed-width address events from a parallel producer onto a single serial wire. A producer offers a word with a four-phase request/acknowledge handshake. The block latches the word, puts a two-bit alignment preamble in front of it and shifts the 34-bit frame out most significant bit first. Each bit is Manchester coded, so a receiver can recover the bit timing from the transitions alone.

The serial side has two handshake wires. The block raises a link request when a burst starts and keeps it up until the receiver acknowledges. After the receiver's acknowledge, the block drops the request and waits for the acknowledge to fall.

Between bursts the data line stays quiet at a constant low level. No filler or comma symbols are sent, and there is no retraining step, so a new event starts its burst on the cycle after it is accepted.

Back-pressure on the parallel side works through the acknowledge level. Once `ev_ack` is high, the producer must keep the word stable until it sees `ev_ack` fall. `ev_ack` falls only after two things have happened: the producer has withdrawn `ev_req`, and the link handshake for that burst has completed. The producer may raise `ev_req` again only after `ev_ack` is low.

Top module: `aer_mc_serializer`

## Requirements
- R1: After reset, `ev_ack`, `link_req` and `ser_out` are all low.
- R2: In idle, a high `ev_req` is accepted at a clock edge. After that edge, `ev_ack` and `link_req` are both high.
- R3: Each burst sends 34 bits: the preamble bits 1 then 0, followed by `ev_word` from bit 31 down to bit 0.
- R4: Manchester coding drives a 0 bit high in its first half and low in its second half. A 1 bit is driven low in its first half and high in its second half.
- R5: Each half-bit lasts `half_cycles` clocks, and a value of 0 acts as 1. The value is captured when the event is accepted, so changing it during a burst has no effect on that burst.
- R6: `ser_out` is low whenever no burst is being shifted: in idle and while waiting on either link acknowledge phase.
- R7: After the last half-bit, `link_req` stays high until `link_ack` is seen high, and falls on the next edge. The block then waits for `link_ack` to go low.
- R8: `ev_ack` stays high until `ev_req` is low and the link handshake has finished. A held `ev_req` starts no second burst.
- R9: The first half-bit of a burst appears on the cycle after acceptance. This holds even when the previous event has just completed, with no extra sequence in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_cycles | input | 8 | Clocks per Manchester half-bit (0 treated as 1) |
| ev_req | input | 1 | Parallel event request (four-phase) |
| ev_word | input | 32 | Event word, stable while request is up |
| ev_ack | output | 1 | Parallel event acknowledge |
| ser_out | output | 1 | Manchester-coded serial data |
| link_req | output | 1 | Serial burst request to receiver |
| link_ack | input | 1 | Serial burst acknowledge from receiver |

## Verification
The bench uses the default widths: 32-bit words and an 8-bit half-bit setting. Bursts are driven with half-bit lengths of 1, 3 and 0, which checks that zero behaves as one and that every half spans the set number of clocks. One burst changes the setting in mid-flight to show that the value captured at acceptance is the one that governs. The bench also stretches the receiver acknowledge, holds the producer request past the end of the link handshake, and drops the request early. These cases exercise each ordering of the two handshakes.

// File: rtl/aer_mc_pkg.sv
package aer_mc_pkg;
  localparam int WORD_W = 32;
  localparam int PRE_W  = 2;
  localparam int HALF_W = 8;
  localparam logic [PRE_W-1:0] PREAMBLE = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_RELEASE
  } ser_state_t;
endpackage

// File: rtl/aer_mc_halfbit_timer.sv
module aer_mc_halfbit_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [HALF_W-1:0] half_cfg,
  output logic              tick
);
  logic [HALF_W-1:0] len_q;
  logic [HALF_W-1:0] cnt_q;
  logic              at_end;

  assign at_end = (cnt_q == len_q - HALF_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= HALF_W'(1);
      cnt_q <= '0;
    end else if (load) begin
      len_q <= (half_cfg == '0) ? HALF_W'(1) : half_cfg;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= at_end ? '0 : cnt_q + HALF_W'(1);
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/aer_mc_shifter.sv
module aer_mc_shifter
  import aer_mc_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int LEAD_W = PRE_W,
  parameter logic [LEAD_W-1:0] LEAD = PREAMBLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic              active,
  input  logic              tick,
  output logic              ser,
  output logic              last
);
  localparam int FRAME_W = LEAD_W + DATA_W;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sreg_q;
  logic [IDX_W-1:0]   idx_q;
  logic               second_q;
  logic               cur_bit;

  assign cur_bit = sreg_q[FRAME_W-1];
  assign ser     = active && (second_q ? cur_bit : !cur_bit);
  assign last    = tick && second_q && (idx_q == IDX_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q   <= '0;
      idx_q    <= '0;
      second_q <= 1'b0;
    end else if (load) begin
      sreg_q   <= {LEAD, word};
      idx_q    <= '0;
      second_q <= 1'b0;
    end else if (active && tick) begin
      if (second_q) begin
        sreg_q   <= {sreg_q[FRAME_W-2:0], 1'b0};
        idx_q    <= idx_q + IDX_W'(1);
        second_q <= 1'b0;
      end else begin
        second_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/aer_mc_link_fsm.sv
module aer_mc_link_fsm
  import aer_mc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_req,
  input  logic link_ack,
  input  logic last,
  output logic load,
  output logic shifting,
  output logic ev_ack,
  output logic link_req
);
  ser_state_t st_q, st_d;
  logic ack_q, ack_d, lreq_q, lreq_d;

  assign load     = (st_q == ST_IDLE) && ev_req;
  assign shifting = (st_q == ST_SHIFT);
  assign ev_ack   = ack_q;
  assign link_req = lreq_q;

  always_comb begin
    st_d   = st_q;
    ack_d  = ack_q;
    lreq_d = lreq_q;
    unique case (st_q)
      ST_IDLE: if (ev_req) begin
        st_d   = ST_SHIFT;
        ack_d  = 1'b1;
        lreq_d = 1'b1;
      end
      ST_SHIFT:   if (last) st_d = ST_WAIT_HI;
      ST_WAIT_HI: if (link_ack) begin
        st_d   = ST_WAIT_LO;
        lreq_d = 1'b0;
      end
      ST_WAIT_LO: if (!link_ack) st_d = ST_RELEASE;
      ST_RELEASE: if (!ev_req) begin
        st_d  = ST_IDLE;
        ack_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ack_q  <= 1'b0;
      lreq_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ack_q  <= ack_d;
      lreq_q <= lreq_d;
    end
  end
endmodule

// File: rtl/aer_mc_serializer.sv
module aer_mc_serializer
  import aer_mc_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] half_cycles,
  input  logic          ev_req,
  input  logic [DW-1:0] ev_word,
  output logic          ev_ack,
  output logic          ser_out,
  output logic          link_req,
  input  logic          link_ack
);
  logic load, shifting, tick, last;

  aer_mc_link_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .link_ack(link_ack),
    .last(last), .load(load), .shifting(shifting),
    .ev_ack(ev_ack), .link_req(link_req)
  );

  aer_mc_halfbit_timer #(.HALF_W(HW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .run(shifting),
    .half_cfg(half_cycles), .tick(tick)
  );

  aer_mc_shifter #(.DATA_W(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .word(ev_word),
    .active(shifting), .tick(tick), .ser(ser_out), .last(last)
  );
endmodule

// File: rtl/aer_mc_serializer_chk.sv
module aer_mc_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_req,
  input logic ev_ack,
  input logic ser_out,
  input logic link_req,
  input logic link_ack
);
  // R6
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_req |-> !ser_out);
  // R2
  req_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_req) |-> $rose(ev_ack));
  // R7
  req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_req) |-> $past(link_ack));
  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ev_ack) |-> !$past(ev_req) && !link_req);
  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && ev_req) |=> ev_ack);
endmodule

bind aer_mc_serializer aer_mc_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_req(ev_req), .ev_ack(ev_ack),
  .ser_out(ser_out), .link_req(link_req), .link_ack(link_ack)
);

// File: tb/aer_mc_serializer_tb.sv
module aer_mc_serializer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] half_cycles = 8'd1;
  logic ev_req = 1'b0;
  logic [31:0] ev_word = '0;
  logic ev_ack, ser_out, link_req;
  logic link_ack = 1'b0;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  aer_mc_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .half_cycles(half_cycles), .ev_req(ev_req),
    .ev_word(ev_word), .ev_ack(ev_ack), .ser_out(ser_out),
    .link_req(link_req), .link_ack(link_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One full event: accept, burst, link handshake, release.
  task automatic run_event(input logic [31:0] w, input logic [7:0] n, input int eff,
                           input logic [7:0] n_mid, input int ack_lag, input bit early_drop);
    logic [33:0] frame;
    int bad;
    frame = {2'b10, w};
    bad = 0;
    @(negedge clk);
    ev_word = w; half_cycles = n; ev_req = 1'b1;
    @(negedge clk);
    check("R2 ev_ack after accept", {31'b0, ev_ack}, 32'd1);
    check("R9 link_req next cycle", {31'b0, link_req}, 32'd1);
    half_cycles = n_mid; // R5: mid-burst change must not matter
    if (early_drop) ev_req = 1'b0;
    for (int s = 0; s < 68 * eff; s++) begin
      logic b, e;
      if (s > 0) @(negedge clk);
      b = frame[33 - s / (2 * eff)];
      e = ((s / eff) % 2 == 1) ? b : ~b;
      if (ser_out !== e) bad++;
    end
    check("R3 R4 R5 burst mismatches", bad, 0);
    for (int k = 0; k <= ack_lag; k++) begin
      @(negedge clk);
      check("R6 line low awaiting ack", {31'b0, ser_out}, 32'd0);
      check("R7 link_req held", {31'b0, link_req}, 32'd1);
    end
    check("R8 ev_ack held through burst", {31'b0, ev_ack}, 32'd1);
    link_ack = 1'b1;
    @(negedge clk);
    check("R7 link_req dropped", {31'b0, link_req}, 32'd0);
    @(negedge clk);
    link_ack = 1'b0;
    repeat (3) @(negedge clk);
    if (!early_drop) begin
      check("R8 ev_ack held while ev_req high", {31'b0, ev_ack}, 32'd1);
      check("R8 no second burst", {31'b0, link_req}, 32'd0);
      ev_req = 1'b0;
      repeat (2) @(negedge clk);
    end
    check("R8 ev_ack released", {31'b0, ev_ack}, 32'd0);
    check("R6 idle line low", {31'b0, ser_out}, 32'd0);
  endtask

  task automatic test_reset();
    repeat (2) @(negedge clk);
    check("R1 ev_ack reset", {31'b0, ev_ack}, 32'd0);
    check("R1 link_req reset", {31'b0, link_req}, 32'd0);
    check("R1 ser_out reset", {31'b0, ser_out}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic test_basic();     run_event(32'hA5C3_0F01, 8'd1, 1, 8'd1, 0, 1'b0); endtask
  task automatic test_slow();      run_event(32'h8000_0001, 8'd3, 3, 8'd3, 4, 1'b0); endtask
  task automatic test_zero_half(); run_event(32'hFFFF_0000, 8'd0, 1, 8'd0, 2, 1'b1); endtask
  task automatic test_mid_change(); run_event(32'h1234_5678, 8'd2, 2, 8'd7, 1, 1'b0); endtask
  task automatic test_back_to_back(); run_event(32'h0000_0000, 8'd1, 1, 8'd1, 0, 1'b1); endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_basic();
    test_slow();
    test_zero_half();
    test_mid_change();
    test_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule